// File: doc/BRIEF.md
# 2B1Q Transmit Symbol Frame Serializer

This block sits on the host side of a line transmitter and delivers one quaternary line symbol per symbol period. The symbol source offers a request (an enable flag and a signed level of +3, +1, -1 or -3) over a valid/ready handshake. A one-entry slot holds the next request while the current frame is still being shifted out.

At the start of each symbol period the block takes the waiting request and turns it into a 16-bit command word. The leading bit is a transmit enable. The next two bits carry the level in a fixed non-binary mapping. The remaining bits are zero. The block shifts the word out MSB first on a generated serial clock and data line. When the shift is done it pulses a baud strobe, whose falling edge commits the symbol. If no request is waiting when a period starts, the block sends a word with the enable cleared, which gives a zero symbol, and pulses an underrun flag.

All timing is counted in system clocks. `HALF_CYC` clocks form each serial clock phase, `BAUD_CLKS` clocks form the strobe pulse, and `SYM_CLKS` clocks form a symbol period. `SYM_CLKS` must be at least 32*`HALF_CYC` + `BAUD_CLKS` + `HALF_CYC`.

Top module: `sym_frame_tx`

## Requirements
- R1: While reset is held, ser_clk_o, ser_dat_o, baud_o and underrun_o are low and sym_ready_o is high.
- R2: Each symbol period carries exactly 16 rising edges of ser_clk_o, one bit per edge, MSB first. ser_dat_o changes only while ser_clk_o is low, and it is stable in the cycle before each rising edge and throughout the high phase.
- R3: Bit 1 of the word is the transmit enable. A request with sym_en_i = 0 produces the word 0x0000 whatever the level.
- R4: With sym_en_i = 1, the level (3-bit two's complement on sym_level_i) sets bits 2 and 3: +3 gives 11, +1 gives 10, -1 gives 01 and -3 gives 00. The resulting words are 0xE000, 0xC000, 0xA000 and 0x8000.
- R5: Bits 4 to 16 of every word are zero.
- R6: A level outside {+3, +1, -1, -3} (that is -4, -2, 0 or +2) is sent as 0x0000, with the enable cleared.
- R7: baud_o goes high once per symbol period, every SYM_CLKS cycles, for BAUD_CLKS cycles, after the 16th serial rising edge. ser_clk_o stays low while baud_o is high.
- R8: sym_ready_o is high exactly when the holding slot is empty. A request is accepted on a clock edge where sym_valid_i and sym_ready_o are both high. Accepted requests go out in order, each in the first frame that starts after it was accepted.
- R9: While the slot is full, sym_ready_o stays low until the next symbol period starts, so a second request offered right after an acceptance is held off.
- R10: If the slot is empty when a period starts, that frame is 0x0000 and underrun_o is high for exactly one cycle within that period. Otherwise underrun_o stays low in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | A symbol request is offered |
| sym_ready_o | output | 1 | Holding slot is empty and can take a request |
| sym_en_i | input | 1 | Transmit enable of the offered request |
| sym_level_i | input | 3 | Signed level of the offered request |
| ser_clk_o | output | 1 | Generated serial clock |
| ser_dat_o | output | 1 | Serial data, valid around ser_clk_o rising edges |
| baud_o | output | 1 | Baud strobe; its falling edge commits the frame |
| underrun_o | output | 1 | One-cycle pulse when a period starts with no request |

## Verification
The bench sweeps every combination of enable and all eight 3-bit level codes. This separates the four legal levels from one another, from the enable override and from the illegal even codes. It rebuilds each word from the serial pins and compares it against a table computed independently in the bench. The requests are streamed back to back, so every request after the first meets a full slot; this shows whether the holding register keeps order and whether it blocks correctly. Gaps in the stream are inserted on purpose to force underrun frames. These tell a true zero-symbol fill, with its flag pulse, apart from a stale repeat of the previous symbol.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef struct packed {
    logic              en;
    logic signed [2:0] lvl;
  } sym_req_t;

  // odd codes are the four legal quaternary levels
  function automatic logic lvl_legal(input logic signed [2:0] lvl);
    return lvl[0];
  endfunction

  // leading three bits of the command word: enable, sign-ish bit, magnitude-ish bit
  function automatic logic [2:0] frame_head(input sym_req_t r);
    logic on;
    on = r.en & lvl_legal(r.lvl);
    return on ? {1'b1, ~r.lvl[2], r.lvl[1]} : 3'b000;
  endfunction

endpackage

// File: rtl/sfs_hold_slot.sv
module sfs_hold_slot
  import sfs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid_i,
  input  sym_req_t in_req_i,
  output logic     ready_o,
  input  logic     take_i,
  output logic     vld_o,
  output sym_req_t req_o
);

  logic accept;

  assign ready_o = !vld_o;
  assign accept  = in_valid_i && ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      req_o <= '0;
    end else begin
      if (take_i) vld_o <= 1'b0;
      if (accept) begin
        vld_o <= 1'b1;
        req_o <= in_req_i;
      end
    end
  end

  // R9
  slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !take_i) |=> !ready_o);

  // R8
  slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && ready_o) |=> vld_o);

endmodule

// File: rtl/sfs_period_timer.sv
module sfs_period_timer #(
  parameter int SYM_CLKS = 80,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_CLKS - 1);

  assign wrap_o = (cnt_o == LAST);

  // reset to the last count so the first edge starts a period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= LAST;
    else        cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
  end

endmodule

// File: rtl/sfs_shift_out.sv
module sfs_shift_out #(
  parameter int FRAME_BITS = 16,
  parameter int HALF_CYC   = 2,
  parameter int BAUD_CLKS  = 2,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic [2:0]       head_i,
  output logic             ser_clk_o,
  output logic             ser_dat_o,
  output logic             baud_o
);

  localparam int BIT_CLKS   = 2 * HALF_CYC;
  localparam int FRAME_CLKS = FRAME_BITS * BIT_CLKS;
  localparam int PH_W       = $clog2(BIT_CLKS);
  localparam int RC_W       = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] FR_END  = CNT_W'(FRAME_CLKS);
  localparam logic [CNT_W-1:0] BD_END  = CNT_W'(FRAME_CLKS + BAUD_CLKS);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BIT_CLKS - 1);
  localparam logic [PH_W-1:0]  PH_HI   = PH_W'(HALF_CYC);

  logic [FRAME_BITS-1:0] shreg;
  logic [PH_W-1:0]       ph;
  logic in_frame, bit_end, sclk_d, sdat_d, baud_d;

  assign in_frame = (cnt_i < FR_END);
  assign bit_end  = in_frame && (ph == PH_LAST);
  assign sclk_d   = in_frame && (ph >= PH_HI);
  assign sdat_d   = in_frame && shreg[FRAME_BITS-1];
  assign baud_d   = (cnt_i >= FR_END) && (cnt_i < BD_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      ph        <= '0;
      ser_clk_o <= 1'b0;
      ser_dat_o <= 1'b0;
      baud_o    <= 1'b0;
    end else begin
      if (load_i) begin
        shreg <= {head_i, {(FRAME_BITS-3){1'b0}}};
        ph    <= '0;
      end else begin
        if (bit_end) shreg <= shreg << 1;
        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      end
      ser_clk_o <= sclk_d;
      ser_dat_o <= sdat_d;
      baud_o    <= baud_d;
    end
  end

  // checker state: serial rising edges seen since the last strobe
  logic            sclk_prev, baud_prev;
  logic [RC_W-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      baud_prev <= 1'b0;
      rises     <= '0;
    end else begin
      sclk_prev <= ser_clk_o;
      baud_prev <= baud_o;
      if (baud_prev && !baud_o)         rises <= '0;
      else if (ser_clk_o && !sclk_prev) rises <= rises + 1'b1;
    end
  end

  // R2
  dat_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_o |-> $stable(ser_dat_o));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_o) |-> (rises == RC_W'(FRAME_BITS)));

  // R7
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_o |-> !ser_clk_o);

endmodule

// File: rtl/sym_frame_tx.sv
module sym_frame_tx
  import sfs_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int HALF_CYC   = 2,
  parameter int BAUD_CLKS  = 2,
  parameter int SYM_CLKS   = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_valid_i,
  output logic              sym_ready_o,
  input  logic              sym_en_i,
  input  logic signed [2:0] sym_level_i,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              baud_o,
  output logic              underrun_o
);

  localparam int CNT_W = $clog2(SYM_CLKS);

  sym_req_t         in_req, slot_req;
  logic             slot_vld, take;
  logic             period_start;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       head;

  assign in_req = {sym_en_i, sym_level_i};

  sfs_period_timer #(.SYM_CLKS(SYM_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk(clk_i), .rst_n(rst_ni), .cnt_o(cnt), .wrap_o(period_start)
  );

  sfs_hold_slot u_slot (
    .clk(clk_i), .rst_n(rst_ni),
    .in_valid_i(sym_valid_i), .in_req_i(in_req), .ready_o(sym_ready_o),
    .take_i(take), .vld_o(slot_vld), .req_o(slot_req)
  );

  assign take = period_start && slot_vld;
  assign head = slot_vld ? frame_head(slot_req) : 3'b000;

  sfs_shift_out #(
    .FRAME_BITS(FRAME_BITS), .HALF_CYC(HALF_CYC),
    .BAUD_CLKS(BAUD_CLKS), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk_i), .rst_n(rst_ni), .cnt_i(cnt), .load_i(period_start),
    .head_i(head), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o), .baud_o(baud_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) underrun_o <= 1'b0;
    else         underrun_o <= period_start && !slot_vld;
  end

  // R10
  underrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> $past(sym_ready_o));

  // R10
  underrun_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);

endmodule

// File: tb/test_sym_frame_tx.sv
module test_sym_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 16;
  localparam int HALF_CYC   = 2;
  localparam int BAUD_CLKS  = 2;
  localparam int SYM_CLKS   = 80;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic sym_valid, sym_en;
  logic signed [2:0] sym_level;
  logic sym_ready, ser_clk, ser_dat, baud, underrun;

  sym_frame_tx #(
    .FRAME_BITS(FRAME_BITS), .HALF_CYC(HALF_CYC),
    .BAUD_CLKS(BAUD_CLKS), .SYM_CLKS(SYM_CLKS)
  ) i_sym_frame_tx (
    .clk_i(clk), .rst_ni(rst_n),
    .sym_valid_i(sym_valid), .sym_ready_o(sym_ready),
    .sym_en_i(sym_en), .sym_level_i(sym_level),
    .ser_clk_o(ser_clk), .ser_dat_o(ser_dat),
    .baud_o(baud), .underrun_o(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit reported = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // expected word from the requirement table (R3, R4, R6)
  function automatic int exp_word(input bit en, input int lvl);
    if (!en) return 0;
    case (lvl)
      3:       return 'hE000;
      1:       return 'hC000;
      -1:      return 'hA000;
      -3:      return 'h8000;
      default: return 0;
    endcase
  endfunction

  int    ew [0:63];
  int    eu [0:63];
  string et [0:63];
  int    pushed = 0;
  int    frames_seen = 0;

  task automatic push(input int w, input int u, input string t);
    ew[pushed] = w;
    eu[pushed] = u;
    et[pushed] = t;
    pushed++;
  endtask

  // monitor: rebuild frames from the pins
  bit prev_sclk = 0, prev_sdat = 0, prev_baud = 0, have_baud = 0;
  int word = 0, nbits = 0, urn = 0, bhi = 0, since = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (underrun) urn++;
      if (ser_clk && !prev_sclk) begin
        check(ser_dat == prev_sdat, "R2 data setup before rising edge", int'(ser_dat), int'(prev_sdat));
        word = (word << 1) | int'(ser_dat);
        nbits++;
      end
      if (baud && !prev_baud) begin
        check(nbits == FRAME_BITS, "R2 rising edges per frame", nbits, FRAME_BITS);
        check((word & 'h1FFF) == 0, "R5 padding bits zero", word & 'h1FFF, 0);
        if (frames_seen < pushed) begin
          check(word == ew[frames_seen], et[frames_seen], word, ew[frames_seen]);
          check(urn == eu[frames_seen], "R10 underrun pulses in period", urn, eu[frames_seen]);
        end else begin
          check(1'b0, "R8 frame beyond expected stream", frames_seen, pushed);
        end
        if (have_baud) check(since == SYM_CLKS, "R7 strobe period", since, SYM_CLKS);
        have_baud = 1'b1;
        since = 0;
        word = 0;
        nbits = 0;
        urn = 0;
        frames_seen++;
      end
      if (baud) bhi++;
      if (!baud && prev_baud) begin
        check(bhi == BAUD_CLKS, "R7 strobe width", bhi, BAUD_CLKS);
        bhi = 0;
      end
      since++;
      prev_sclk = ser_clk;
      prev_sdat = ser_dat;
      prev_baud = baud;
    end
  end

  // offer one request; returns once accepted; first_rdy is ready before the first edge
  task automatic send(input bit en, input int lvl, output bit first_rdy);
    sym_valid = 1'b1;
    sym_en    = en;
    sym_level = 3'(lvl);
    first_rdy = sym_ready;
    forever begin
      bit r;
      r = sym_ready;
      @(negedge clk);
      if (r) break;
    end
    sym_valid = 1'b0;
  endtask

  initial begin
    bit fr;
    int n;
    rst_n = 1'b0;
    sym_valid = 1'b0;
    sym_en = 1'b0;
    sym_level = '0;
    repeat (3) @(negedge clk);
    // R1
    check({ser_clk, ser_dat, baud, underrun} == 4'b0000, "R1 outputs low in reset",
          int'({ser_clk, ser_dat, baud, underrun}), 0);
    check(sym_ready == 1'b1, "R1 ready high in reset", int'(sym_ready), 1);
    push(0, 1, "R10 first period has no request");
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep, streamed back to back
    n = 0;
    for (int en = 0; en < 2; en++) begin
      for (int lvl = -4; lvl < 4; lvl++) begin
        send(bit'(en), lvl, fr);
        if (n == 0) check(fr == 1'b1, "R8 ready with empty slot", int'(fr), 1);
        else        check(fr == 1'b0, "R9 ready low while slot full", int'(fr), 0);
        if (en == 0)          push(exp_word(0, lvl), 0, "R3 enable cleared gives zero word");
        else if (lvl % 2 != 0) push(exp_word(1, lvl), 0, "R4 level mapping");
        else                   push(exp_word(1, lvl), 0, "R6 illegal level gives zero word");
        n++;
      end
    end

    // forced gap -> underrun, then recovery
    push(0, 1, "R10 empty slot gives zero word");
    wait (frames_seen >= pushed);
    @(negedge clk);
    send(1'b1, -3, fr);
    check(fr == 1'b1, "R8 ready after underrun period", int'(fr), 1);
    push(exp_word(1, -3), 0, "R4 level -3 after gap");
    push(0, 1, "R10 second gap");
    wait (frames_seen >= pushed);
    @(negedge clk);
    send(1'b1, 3, fr);
    push(exp_word(1, 3), 0, "R4 level +3 after gap");
    wait (frames_seen >= pushed);
    repeat (5) @(negedge clk);
    check(frames_seen == pushed, "R8 all accepted requests sent", frames_seen, pushed);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d frames", frames_seen, pushed);
      report();
      $finish;
    end
  end

endmodule